// File: doc/BRIEF.md
# Interrupt Source Routing Unit

This block keeps the programming state of a small set of interrupt sources and decides, every clock cycle, which pending source may be handed to which CPU. Each source has a vector/priority word and a destination word, both reached through an indexed register port. The block captures its input lines as edge or level events and tracks a pending bit and an in-service (activity) flag per source. It raises a one-cycle request, tagged with the source index, to the per-CPU acknowledge logic that sits beside it.

A source is routed in one of two ways. In directed mode it goes to every CPU named in its destination mask. In distributed mode it goes to exactly one CPU, chosen by rotating through the mask from the CPU that was served last. A CPU takes the request only when the source priority is above the task priority that CPU currently presents. The acknowledge side reports back through a single acknowledge strobe, which ends the in-service state.

Top module: `irq_route_unit`

## Requirements
- R1: After reset, each vector/priority word reads with the mask bit (31) set, priority 0, vector 0, activity bit (30) clear, delivery-mode bit (29) equal to the source's DIST_SRC parameter bit and sense bit (22) equal to its LEVEL_SRC parameter bit. Every destination word reads 0x00000001 (CPU 0), and no raise is driven.
- R2: A write to a vector/priority word (reg_dst_sel=0) updates only the mask (bit 31), priority (bits 19:16) and vector (bits VEC_W-1:0). The activity bit keeps its value, mode and sense stay fixed, and all other bits read 0.
- R3: A write to a destination word (reg_dst_sel=1) keeps bit 31, bit 30 and the CPU target bits NUM_CPU-1:0; all other bits read 0.
- R4: A source is not delivered while it is not pending, while it is masked, while its priority is 0, while its activity bit is set, or while its target bits are all zero. A pending source that is blocked stays pending and is delivered once the block is lifted.
- R5: A CPU accepts a source only if the source priority is strictly greater than that CPU's 4-bit task_pri field. On delivery, the activity bit is set and raise_valid pulses for one cycle on each accepting CPU, with raise_src equal to the source index. The pulse appears on the second rising clock edge after an input edge and on the first edge after a blocking condition is cleared. If no targeted CPU accepts, nothing is delivered and the source stays pending.
- R6: In directed mode (bit 29 = 0), delivery goes to every targeted CPU that accepts.
- R7: In distributed mode (bit 29 = 1), the CPUs are searched starting after the last-served CPU and wrapping at NUM_CPU. The first targeted CPU found receives the source and becomes the new last-served CPU, which is 0 after reset. A mask holding only the last-served CPU sends the source to that CPU again.
- R8: For a level source (sense = 1), pending equals the input level sampled at each edge, and a low level clears the activity bit.
- R9: For an edge source (sense = 0), a rising input sets pending and a falling input has no effect.
- R10: An acknowledge (ack_valid with ack_idx) clears that source's activity bit and, for an edge source, also its pending bit.
- R11: At most one source is delivered per cycle. When several sources are eligible at once, the lowest index goes first and the others follow in later cycles, regardless of priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt input lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_dst_sel | input | 1 | 0 selects vector/priority word, 1 selects destination word |
| reg_idx | input | IDX_W | Source index for register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| task_pri | input | 4*NUM_CPU | Current task priority of each CPU, 4 bits each |
| ack_valid | input | 1 | Acknowledge strobe from the per-CPU logic |
| ack_idx | input | IDX_W | Source being acknowledged |
| raise_valid | output | NUM_CPU | One-cycle delivery request per CPU |
| raise_src | output | IDX_W*NUM_CPU | Source index carried with each request |

## Verification
A stuck pending or activity bit shows up within two cycles: either a source never raises again, or it raises a second time without an acknowledge. The activity bit can also be read directly through the register port. A wrong round-robin pointer shows up on the very next distributed delivery as a request on the wrong CPU, so the bench runs long rotations over several masks. Broken eligibility or acceptance logic appears as a raise pattern that disagrees with the priority arithmetic. A full sweep of priorities against fixed task priorities exposes it.

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
  parameter int NUM_SRC = 4,
  parameter int NUM_CPU = 3,
  parameter int VEC_W   = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = 4'b0100,
  parameter logic [NUM_SRC-1:0] DIST_SRC  = 4'b1000,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_in,
  input  logic                     reg_we,
  input  logic                     reg_dst_sel,
  input  logic [IDX_W-1:0]         reg_idx,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [4*NUM_CPU-1:0]     task_pri,
  input  logic                     ack_valid,
  input  logic [IDX_W-1:0]         ack_idx,
  output logic [NUM_CPU-1:0]       raise_valid,
  output logic [IDX_W*NUM_CPU-1:0] raise_src
);
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic             mask_q [NUM_SRC];
  logic [3:0]       pri_q  [NUM_SRC];
  logic [VEC_W-1:0] vec_q  [NUM_SRC];
  logic             ext_q  [NUM_SRC];
  logic             crit_q [NUM_SRC];
  logic [NUM_CPU-1:0] tgt_q [NUM_SRC];
  logic [CPU_W-1:0] last_q [NUM_SRC];
  logic [NUM_SRC-1:0] act_q, pend_q, lvl_q;

  logic [NUM_CPU-1:0] cand [NUM_SRC];
  logic [NUM_CPU-1:0] acc  [NUM_SRC];
  logic [NUM_SRC-1:0] ok;
  logic               found;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_CPU-1:0] win_acc;

  always_comb begin
    found = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      cand[s] = '0;
      if (tgt_q[s] == (NUM_CPU'(1) << last_q[s]) || !DIST_SRC[s]) begin
        cand[s] = tgt_q[s];
      end else begin
        found = 1'b0;
        for (int k = 1; k <= NUM_CPU; k++) begin
          if (!found && tgt_q[s][(int'(last_q[s]) + k) % NUM_CPU]) begin
            cand[s][(int'(last_q[s]) + k) % NUM_CPU] = 1'b1;
            found = 1'b1;
          end
        end
      end
      for (int c = 0; c < NUM_CPU; c++)
        acc[s][c] = cand[s][c] && (pri_q[s] > task_pri[4*c +: 4]);
      ok[s] = pend_q[s] && !mask_q[s] && (pri_q[s] != 4'd0) && !act_q[s]
              && (tgt_q[s] != '0) && (acc[s] != '0);
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_acc   = '0;
    for (int s = NUM_SRC-1; s >= 0; s--) begin
      if (ok[s]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(s);
        win_acc   = acc[s];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_idx) < NUM_SRC) begin
      if (reg_dst_sel) begin
        reg_rdata[31] = ext_q[reg_idx];
        reg_rdata[30] = crit_q[reg_idx];
        reg_rdata[NUM_CPU-1:0] = tgt_q[reg_idx];
      end else begin
        reg_rdata[31]    = mask_q[reg_idx];
        reg_rdata[30]    = act_q[reg_idx];
        reg_rdata[29]    = DIST_SRC[reg_idx];
        reg_rdata[22]    = LEVEL_SRC[reg_idx];
        reg_rdata[19:16] = pri_q[reg_idx];
        reg_rdata[VEC_W-1:0] = vec_q[reg_idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        mask_q[s] <= 1'b1;
        pri_q[s]  <= '0;
        vec_q[s]  <= '0;
        ext_q[s]  <= 1'b0;
        crit_q[s] <= 1'b0;
        tgt_q[s]  <= NUM_CPU'(1);
        last_q[s] <= '0;
      end
      act_q       <= '0;
      pend_q      <= '0;
      lvl_q       <= '0;
      raise_valid <= '0;
      raise_src   <= '0;
    end else begin
      lvl_q <= irq_in;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (LEVEL_SRC[s]) pend_q[s] <= irq_in[s];
        else if (irq_in[s] && !lvl_q[s]) pend_q[s] <= 1'b1;
      end
      raise_valid <= win_valid ? win_acc : '0;
      for (int c = 0; c < NUM_CPU; c++)
        raise_src[IDX_W*c +: IDX_W] <= win_idx;
      if (win_valid) begin
        act_q[win_idx] <= 1'b1;
        if (DIST_SRC[win_idx]) begin
          for (int c = 0; c < NUM_CPU; c++)
            if (win_acc[c]) last_q[win_idx] <= CPU_W'(c);
        end
      end
      if (ack_valid && int'(ack_idx) < NUM_SRC) begin
        act_q[ack_idx] <= 1'b0;
        if (!LEVEL_SRC[ack_idx]) pend_q[ack_idx] <= 1'b0;
      end
      for (int s = 0; s < NUM_SRC; s++)
        if (LEVEL_SRC[s] && !irq_in[s]) act_q[s] <= 1'b0;
      if (reg_we && int'(reg_idx) < NUM_SRC) begin
        if (reg_dst_sel) begin
          ext_q[reg_idx]  <= reg_wdata[31];
          crit_q[reg_idx] <= reg_wdata[30];
          tgt_q[reg_idx]  <= reg_wdata[NUM_CPU-1:0];
        end else begin
          mask_q[reg_idx] <= reg_wdata[31];
          pri_q[reg_idx]  <= reg_wdata[19:16];
          vec_q[reg_idx]  <= reg_wdata[VEC_W-1:0];
        end
      end
    end
  end

  logic [3:0]         sel_pri;
  logic [NUM_CPU-1:0] sel_tgt;
  logic               sel_mask;
  assign sel_pri  = pri_q[win_idx];
  assign sel_tgt  = tgt_q[win_idx];
  assign sel_mask = mask_q[win_idx];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_PRI_OVER_TASK: assert property (@(posedge clk) disable iff (!rst_n)
      raise_valid[c] |-> ($past(sel_pri) > $past(task_pri[4*c +: 4]))); // R5
    AST_DEST_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
      raise_valid[c] |-> $past(sel_tgt[c])); // R6
    AST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      raise_valid[c] |-> !$past(sel_mask)); // R4
    AST_SAME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_valid[c] && raise_valid[0]) |->
        (raise_src[IDX_W*c +: IDX_W] == raise_src[IDX_W-1:0])); // R11
  end

  AST_DIST_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ((|raise_valid) && DIST_SRC[raise_src[IDX_W-1:0]]) |-> $onehot0(raise_valid)); // R7
endmodule

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NC = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic reg_we = 1'b0;
  logic reg_dst_sel = 1'b0;
  logic [IW-1:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4*NC-1:0] task_pri = '0;
  logic ack_valid = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic [NC-1:0] raise_valid;
  logic [IW*NC-1:0] raise_src;

  int checks = 0;
  int errors = 0;

  irq_route_unit #(.NUM_SRC(NS), .NUM_CPU(NC), .VEC_W(8),
    .LEVEL_SRC(4'b0100), .DIST_SRC(4'b1000)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_dst_sel(reg_dst_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .task_pri(task_pri), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .raise_valid(raise_valid), .raise_src(raise_src));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic dsel, input int idx, input logic [31:0] d);
    reg_we = 1'b1; reg_dst_sel = dsel; reg_idx = IW'(idx); reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic dsel, input int idx, input logic [31:0] exp);
    reg_dst_sel = dsel; reg_idx = IW'(idx);
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ack(input int idx);
    ack_valid = 1'b1; ack_idx = IW'(idx);
    step();
    ack_valid = 1'b0;
  endtask

  task automatic chk_raise(input string req, input logic [NC-1:0] exp, input int src);
    chk(req, 32'(raise_valid), 32'(exp));
    for (int c = 0; c < NC; c++)
      if (exp[c]) chk(req, 32'(raise_src[IW*c +: IW]), 32'(src));
  endtask

  function automatic int next_cpu(input int last, input logic [NC-1:0] dst);
    for (int k = 1; k <= NC; k++)
      if (dst[(last + k) % NC]) return (last + k) % NC;
    return last;
  endfunction

  initial begin
    logic [NC-1:0] exp;
    int last;
    logic [NC-1:0] dmask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 0, 0, 32'h8000_0000);
    rd("R1", 0, 1, 32'h8000_0000);
    rd("R1", 0, 2, 32'h8040_0000);
    rd("R1", 0, 3, 32'hA000_0000);
    for (int s = 0; s < NS; s++) rd("R1", 1, s, 32'h0000_0001);
    chk("R1", 32'(raise_valid), 0);

    // R2 / R3 field masking on write
    wr(0, 0, 32'hFFFF_FFFF); rd("R2", 0, 0, 32'h800F_00FF);
    wr(0, 2, 32'hFFFF_FFFF); rd("R2", 0, 2, 32'h804F_00FF);
    wr(0, 3, 32'hFFFF_FFFF); rd("R2", 0, 3, 32'hA00F_00FF);
    wr(1, 0, 32'hFFFF_FFFF); rd("R3", 1, 0, 32'hC000_0007);
    wr(1, 1, 32'h3FFF_FFFA); rd("R3", 1, 1, 32'h0000_0002);

    // R5/R6 priority sweep, directed source 0 to all CPUs
    task_pri = {4'd15, 4'd9, 4'd5};
    wr(1, 0, 32'h0000_0007);
    for (int p = 0; p < 16; p++) begin
      wr(0, 0, (32'(p) << 16) | 32'(p));
      irq_in[0] = 1'b1;
      step(); step();
      exp = {1'b0, (p > 9), (p > 5)};
      chk_raise("R5", exp, 0);
      irq_in[0] = 1'b0;
      ack(0);
      chk("R5", 32'(raise_valid), 0);
      rd("R10", 0, 0, (32'(p) << 16) | 32'(p));
    end

    // R6 directed to a single non-last CPU
    task_pri = '0;
    wr(1, 0, 32'h0000_0002);
    wr(0, 0, 32'h0003_0011);
    irq_in[0] = 1'b1; step(); step();
    chk_raise("R6", 3'b010, 0);
    // R9 falling edge ignored
    ack(0);
    irq_in[0] = 1'b0; step(); step(); step();
    chk("R9", 32'(raise_valid), 0);
    rd("R9", 0, 0, 32'h0003_0011);

    // R4 masked, zero priority, zero destination
    wr(1, 1, 32'h0000_0001);
    wr(0, 1, 32'h8008_0000);
    irq_in[1] = 1'b1; step(); step();
    chk("R4", 32'(raise_valid), 0);
    irq_in[1] = 1'b0;
    wr(0, 1, 32'h0008_0000); step();
    chk_raise("R4", 3'b001, 1);
    ack(1);
    wr(0, 1, 32'h0000_0000);
    irq_in[1] = 1'b1; step(); step();
    chk("R4", 32'(raise_valid), 0);
    irq_in[1] = 1'b0;
    wr(0, 1, 32'h0004_0000); step();
    chk_raise("R4", 3'b001, 1);
    ack(1);
    wr(1, 1, 32'h0000_0000);
    irq_in[1] = 1'b1; step(); step();
    chk("R4", 32'(raise_valid), 0);
    irq_in[1] = 1'b0;
    wr(1, 1, 32'h0000_0001); step();
    chk_raise("R4", 3'b001, 1);

    // R4 activity blocks, R2 write keeps activity, R10 ack clears
    step(); irq_in[1] = 1'b1; step(); step();
    chk("R4", 32'(raise_valid), 0);
    rd("R4", 0, 1, 32'h4004_0000);
    wr(0, 1, 32'h0004_0000);
    rd("R2", 0, 1, 32'h4004_0000);
    irq_in[1] = 1'b0;
    ack(1);
    rd("R10", 0, 1, 32'h0004_0000);
    step();
    chk("R10", 32'(raise_valid), 0);

    // R5 rejection keeps pending
    task_pri = {4'd0, 4'd0, 4'd12};
    irq_in[1] = 1'b1; step(); step();
    chk("R5", 32'(raise_valid), 0);
    irq_in[1] = 1'b0;
    task_pri = '0; step();
    chk_raise("R5", 3'b001, 1);
    ack(1);

    // R8 level source 2
    wr(1, 2, 32'h0000_0002);
    wr(0, 2, 32'h000A_0000);
    irq_in[2] = 1'b1; step(); step();
    chk_raise("R8", 3'b010, 2);
    rd("R8", 0, 2, 32'h404A_0000);
    step();
    chk("R8", 32'(raise_valid), 0);
    irq_in[2] = 1'b0; step();
    rd("R8", 0, 2, 32'h004A_0000);
    irq_in[2] = 1'b1; step(); step();
    chk_raise("R8", 3'b010, 2);
    irq_in[2] = 1'b0; step();
    wr(0, 2, 32'h800A_0000);
    irq_in[2] = 1'b1; step();
    irq_in[2] = 1'b0; step();
    wr(0, 2, 32'h000A_0000); step(); step();
    chk("R8", 32'(raise_valid), 0);

    // R7 distributed rotation on source 3
    last = 0;
    wr(0, 3, 32'h0003_0000);
    for (int m = 0; m < 3; m++) begin
      dmask = (m == 0) ? 3'b111 : (m == 1) ? 3'b101 : 3'b110;
      wr(1, 3, 32'(dmask));
      for (int n = 0; n < 5; n++) begin
        irq_in[3] = 1'b1; step(); step();
        last = next_cpu(last, dmask);
        chk_raise("R7", NC'(1) << last, 3);
        irq_in[3] = 1'b0;
        ack(3);
      end
    end
    wr(1, 3, 32'(NC'(1) << last));
    irq_in[3] = 1'b1; step(); step();
    chk_raise("R7", NC'(1) << last, 3);
    irq_in[3] = 1'b0;
    ack(3);

    // R11 lowest index first, one per cycle
    wr(1, 0, 32'h0000_0001); wr(0, 0, 32'h0002_0000);
    wr(1, 1, 32'h0000_0001); wr(0, 1, 32'h0009_0000);
    irq_in[1:0] = 2'b11; step(); step();
    chk_raise("R11", 3'b001, 0);
    step();
    chk_raise("R11", 3'b001, 1);
    irq_in[1:0] = 2'b00;
    ack(0); ack(1);
    step();
    chk("R11", 32'(raise_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule